// File: doc/BRIEF.md
# Interrupt Cause and Mask Controller

This block gathers up to 32 interrupt requests into one interrupt line for a processor. It also exposes a small register window on a 32-bit bus. Most requests are level signals: each one shows up in the cause register while its input is high and disappears when the input drops. A mask register decides which causes can drive the processor interrupt. Software reads the cause register, picks the lowest pending enabled bit, and services it.

One source is different. A front-panel reset switch produces a sticky cause bit on each press, and software clears that bit by writing a one to it. A second cause bit shows the switch's present level. A separate register starts a platform reset: any write to it produces a one-cycle pulse on a reset output. Every source input and the switch pass through a two-flop synchroniser before they are used.

Top module: `irq_cause_ctrl`

## Requirements
- R1: Byte offset 0x00 reads the cause register and 0x04 reads the mask register. Every other offset, including 0x24, reads as 0.
- R2: The mask register is 32 bits wide and is loaded in full by a write to 0x04. It reads back exactly as written and is 0 after reset.
- R3: `irq_out` is high exactly when the bitwise AND of cause and mask is non-zero, so it is low whenever the mask is 0.
- R4: Cause bits other than 1 and 16 follow `src_in` of the same position, with a two-cycle synchroniser delay. Writes to these bits have no effect.
- R5: Cause bit 1 is set when the synchronised `sw_state` falls from 1 to 0, which is a press. It stays set after the switch is released. `src_in[1]` and `src_in[16]` are ignored.
- R6: Writing 1 to cause bit 1 clears it, and writing 0 there leaves it unchanged. If a press edge and a clearing write arrive in the same cycle, the bit ends set.
- R7: Cause bit 16 reads the synchronised live `sw_state`: 1 means released and 0 means pressed. Writes to this bit have no effect.
- R8: Any write to offset 0x24 makes `plat_rst` high for exactly one cycle, in the cycle after the write strobe. At all other times `plat_rst` is low.
- R9: Writing 0x00000000 to the mask and then 0xFFFFFFFF to the cause leaves `irq_out` low and cause bit 1 clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 6 | Byte offset of the access |
| wr_en | input | 1 | Write strobe |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| src_in | input | 32 | Level interrupt request inputs |
| sw_state | input | 1 | Reset switch level (0 = pressed) |
| irq_out | output | 1 | Interrupt request to the processor |
| plat_rst | output | 1 | One-cycle platform reset pulse |

## Verification
The two actions that can land in the same cycle are a switch-press edge setting cause bit 1 and a software write of 1 clearing that same bit. The bench counts clock edges from the moment it lowers `sw_state` so that the clearing write's strobe falls on exactly the edge where the synchronised falling edge is detected. It then expects bit 1 to read as set. A second clear, issued with no press edge present, must then read 0. This shows that the bit was kept by the press edge winning the conflict, and not because the clear does nothing.

// File: rtl/irq_cause_ctrl.sv
module irq_cause_ctrl #(
  parameter int NSRC = 32,
  parameter int AW = 6,
  parameter int SW_LATCH_BIT = 1,
  parameter int SW_STATE_BIT = 16,
  parameter logic [AW-1:0] OFS_CAUSE = 6'h00,
  parameter logic [AW-1:0] OFS_MASK  = 6'h04,
  parameter logic [AW-1:0] OFS_RESET = 6'h24
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   addr,
  input  logic            wr_en,
  input  logic [NSRC-1:0] wdata,
  output logic [NSRC-1:0] rdata,
  input  logic [NSRC-1:0] src_in,
  input  logic            sw_state,
  output logic            irq_out,
  output logic            plat_rst
);
  localparam logic [NSRC-1:0] ONE = {{(NSRC-1){1'b0}}, 1'b1};
  localparam logic [NSRC-1:0] LEVEL_BITS = ~((ONE << SW_LATCH_BIT) | (ONE << SW_STATE_BIT));

  logic [NSRC-1:0] src_s1, src_s2, mask_q, cause_vec;
  logic sw_s1, sw_s2, sw_prev, sw_latch, rst_q;

  wire press_edge = sw_prev & ~sw_s2;
  wire clr_write  = wr_en && addr == OFS_CAUSE && wdata[SW_LATCH_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_s1  <= '0;
      src_s2  <= '0;
      sw_s1   <= 1'b1;
      sw_s2   <= 1'b1;
      sw_prev <= 1'b1;
    end else begin
      src_s1  <= src_in;
      src_s2  <= src_s1;
      sw_s1   <= sw_state;
      sw_s2   <= sw_s1;
      sw_prev <= sw_s2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q   <= '0;
      sw_latch <= 1'b0;
      rst_q    <= 1'b0;
    end else begin
      if (wr_en && addr == OFS_MASK) mask_q <= wdata;
      if (press_edge)     sw_latch <= 1'b1;
      else if (clr_write) sw_latch <= 1'b0;
      rst_q <= wr_en && addr == OFS_RESET;
    end
  end

  assign cause_vec = (src_s2 & LEVEL_BITS)
                   | (NSRC'(sw_latch) << SW_LATCH_BIT)
                   | (NSRC'(sw_s2) << SW_STATE_BIT);

  always_comb begin
    case (addr)
      OFS_CAUSE: rdata = cause_vec;
      OFS_MASK:  rdata = mask_q;
      default:   rdata = '0;
    endcase
  end

  assign irq_out  = |(cause_vec & mask_q);
  assign plat_rst = rst_q;
endmodule

module irq_cause_ctrl_chk #(
  parameter int NSRC = 32,
  parameter int AW = 6,
  parameter int SW_LATCH_BIT = 1,
  parameter logic [AW-1:0] OFS_CAUSE = 6'h00,
  parameter logic [AW-1:0] OFS_MASK  = 6'h04,
  parameter logic [AW-1:0] OFS_RESET = 6'h24
) (
  input logic            clk,
  input logic            rst_n,
  input logic [AW-1:0]   addr,
  input logic            wr_en,
  input logic [NSRC-1:0] wdata,
  input logic            irq_out,
  input logic            plat_rst,
  input logic [NSRC-1:0] mask_q,
  input logic            sw_latch,
  input logic            sw_s2
);
  AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == OFS_MASK) |=> mask_q == $past(wdata)); // R2
  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> !irq_out); // R3
  AST_LATCH_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_latch && !(wr_en && addr == OFS_CAUSE && wdata[SW_LATCH_BIT])) |=> sw_latch); // R5
  AST_LATCH_NEEDS_PRESS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sw_latch) |-> $past(!sw_s2)); // R5
  AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    plat_rst |=> !plat_rst); // R8
  AST_RST_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    plat_rst |-> $past(wr_en && addr == OFS_RESET)); // R8
endmodule

bind irq_cause_ctrl irq_cause_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
  .irq_out(irq_out), .plat_rst(plat_rst), .mask_q(mask_q),
  .sw_latch(sw_latch), .sw_s2(sw_s2)
);

// File: tb/irq_cause_ctrl_tb.sv
module irq_cause_ctrl_tb;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, sw_state = 1'b1;
  logic [5:0] addr = '0;
  logic [31:0] wdata = '0, src_in = '0, rdata;
  logic irq_out, plat_rst;
  int checks = 0, fails = 0;
  bit done = 0;
  localparam logic [31:0] LEVEL = ~((32'd1 << 1) | (32'd1 << 16));

  always #10 clk = ~clk;

  irq_cause_ctrl u_dut (.clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
    .rdata(rdata), .src_in(src_in), .sw_state(sw_state), .irq_out(irq_out), .plat_rst(plat_rst));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic waitn(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  initial begin
    logic [31:0] v;
    waitn(3); rst_n = 1'b1; waitn(1);
    rd(6'h04, v); chk("R2 reset mask", v, 32'h0);
    rd(6'h00, v); chk("R7 reset cause", v, 32'h0001_0000);
    chk("R3 reset irq", {31'b0, irq_out}, 32'h0);
    chk("R8 reset plat_rst", {31'b0, plat_rst}, 32'h0);

    for (int a = 0; a < 64; a += 4) begin
      if (a != 0 && a != 4) begin
        rd(6'(a), v); chk("R1 unmapped read", v, 32'h0);
      end
    end

    for (int i = 0; i < 32; i++) begin
      wr(6'h04, 32'd1 << i); rd(6'h04, v); chk("R2 mask walk", v, 32'd1 << i);
      wr(6'h04, ~(32'd1 << i)); rd(6'h04, v); chk("R2 mask walk inv", v, ~(32'd1 << i));
    end

    for (int i = 0; i < 32; i++) begin
      logic [31:0] exp;
      src_in = 32'd1 << i; waitn(3);
      exp = ((32'd1 << i) & LEVEL) | 32'h0001_0000;
      rd(6'h00, v); chk("R4 level follow", v, exp);
      wr(6'h00, 32'hFFFF_FFFF); rd(6'h00, v); chk("R4 cause write ignored", v, exp);
      wr(6'h04, 32'd1 << i); chk("R3 irq enabled bit", {31'b0, irq_out}, {31'b0, |(exp & (32'd1 << i))});
      wr(6'h04, ~(32'd1 << i)); chk("R3 irq other bits", {31'b0, irq_out}, {31'b0, |(exp & ~(32'd1 << i))});
    end
    src_in = 32'h0; wr(6'h04, 32'h0); waitn(3);

    sw_state = 1'b0; waitn(4);
    rd(6'h00, v); chk("R5 R7 press latched, live low", v, 32'h0000_0002);
    wr(6'h04, 32'h2); chk("R3 latch raises irq", {31'b0, irq_out}, 32'h1);
    sw_state = 1'b1; waitn(4);
    rd(6'h00, v); chk("R5 sticky after release", v, 32'h0001_0002);
    wr(6'h00, 32'hFFFF_FFFD); rd(6'h00, v); chk("R6 write zero keeps", v, 32'h0001_0002);
    wr(6'h00, 32'h2); rd(6'h00, v); chk("R6 W1C clears", v, 32'h0001_0000);
    chk("R3 irq drops", {31'b0, irq_out}, 32'h0);

    @(negedge clk); sw_state = 1'b0;
    @(negedge clk); @(negedge clk);
    wr_en = 1'b1; addr = 6'h00; wdata = 32'h2;
    @(negedge clk); wr_en = 1'b0;
    rd(6'h00, v); chk("R6 press wins over clear", v, 32'h0000_0002);
    wr(6'h00, 32'h2); rd(6'h00, v); chk("R6 clear while held", v, 32'h0000_0000);
    sw_state = 1'b1; waitn(4);

    wr(6'h24, 32'h0); chk("R8 pulse high", {31'b0, plat_rst}, 32'h1);
    @(negedge clk); chk("R8 pulse one cycle", {31'b0, plat_rst}, 32'h0);
    wr(6'h20, 32'h0); chk("R8 other offset no pulse", {31'b0, plat_rst}, 32'h0);

    src_in = 32'hFFFF_FFFF; sw_state = 1'b0; waitn(4); sw_state = 1'b1;
    wr(6'h04, 32'hFFFF_FFFF); waitn(3);
    chk("R3 all enabled irq", {31'b0, irq_out}, 32'h1);
    wr(6'h04, 32'h0); wr(6'h00, 32'hFFFF_FFFF);
    chk("R9 quiesce irq", {31'b0, irq_out}, 32'h0);
    rd(6'h00, v); chk("R9 quiesce latch", v & 32'h2, 32'h0);
    rd(6'h04, v); chk("R9 quiesce mask", v, 32'h0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule